// File: doc/BRIEF.md
# Relocatable I/O Control Register Block

This block is the glue-logic register set of a small single-board computer, sitting on an 8-bit ISA-style bus. Three control registers live at fixed I/O addresses. A fourth and fifth register form a pair whose base address software can move between four I/O locations by writing a two-bit field. The registers hold page bits that drive the upper address lines of two paged memory windows and an enable bit that opens the flash window. Reads return board status and strap inputs.

The bus strobes are active low and are sampled on `clk`. I/O writes go through a small bus-cycle state machine. In `ST_IDLE`, a low `iow_n` on a decoded address moves it to `ST_WRITE`, latching the target and the data. `ST_WRITE` commits the write in a single cycle and always moves on to `ST_WAIT`. `ST_WAIT` holds until `iow_n` goes high, then returns to `ST_IDLE`, so each strobe commits exactly once. Reads are combinational while `ior_n` is low. Memory chip selects are decoded combinationally from the address and the `memr_n`/`memw_n` strobes.

Top module: `ioreg_glue`

## Requirements
- R1: After reset, the flash page is 0, the SRAM page is 0, the flash window is closed, the relocatable pair sits at 180h, and reserved bit 5 of the page register is 0.
- R2: The register at 231h reads {cmos_ok, video_en, flash enable, 0, 0, 0, disk_en, 0} from bit 7 down to bit 0. Only bit 5 (flash enable) is writable; writes to every other bit have no effect.
- R3: The register at 233h holds the flash page in bits 3:0, which drive `flash_page` (flash address lines 18:15). Bits 7:4 read `panel_sel` and ignore writes.
- R4: The register at 234h bits 7:6 select the pair base: 00=180h, 01=2E0h, 10=3E0h, 11=300h. Bits 5:0 read 0. From the next bus cycle after the write, the new base decodes and the old base no longer responds.
- R5: The register at base+0 is read-only and returns `batt_fail` in bit 0, with 0 in bits 7:1.
- R6: The register at base+1 holds the SRAM page in bits 2:0, which drive `sram_page`, and a reserved bit 5 that stores and returns its value. All other bits read 0.
- R7: `sram_cs_n` is low only while `memr_n` or `memw_n` is low and the address lies in CC000h–CFFFFh.
- R8: `flash_cs_n` is low only while a memory strobe is low, the address lies in D0000h–D7FFFh, and the flash enable bit is 1.
- R9: `data_oe` is high only while `ior_n` is low and the address decodes to one of the five registers.
- R10: I/O decode uses address bits 9:0 only. `dev_addr` equals bus address bits 14:0.
- R11: One low period of `iow_n` commits exactly one write, and a page output changes only on the cycle that commits a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 20 | ISA address |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data toward the bus |
| data_oe | output | 1 | Data pad output enable |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| disk_en | input | 1 | Disk module enable status |
| video_en | input | 1 | On-board video enable status |
| cmos_ok | input | 1 | 1 = CMOS okay, 0 = clear request |
| batt_fail | input | 1 | 1 = backup battery failed |
| panel_sel | input | 4 | Panel-type strap |
| flash_page | output | 4 | Flash address lines 18:15 |
| sram_page | output | 3 | SRAM address lines 17:15 |
| dev_addr | output | 15 | Lower device address lines |
| flash_cs_n | output | 1 | Flash window chip select |
| sram_cs_n | output | 1 | SRAM window chip select |

## Verification
The bench builds the block with its default parameters: a 10-bit I/O decode, a 16 KB SRAM window at CC000h and a 32 KB flash window at D0000h. With these values the bench can walk every one of the four pair bases, probe the edges of both windows one byte inside and one byte outside, and test aliasing through address bits above bit 9. The status inputs are tied to a mixed pattern of ones and zeros, so each bit position in the read data is distinguishable.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

    localparam logic [9:0] ADR_LED   = 10'h231;
    localparam logic [9:0] ADR_FLASH = 10'h233;
    localparam logic [9:0] ADR_LOC   = 10'h234;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LED,
        SEL_FLASH,
        SEL_LOC,
        SEL_STAT,
        SEL_PAGE
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_WAIT
    } bus_st_e;

    function automatic logic [9:0] pair_base(input logic [1:0] loc);
        unique case (loc)
            2'b00: pair_base = 10'h180;
            2'b01: pair_base = 10'h2E0;
            2'b10: pair_base = 10'h3E0;
            default: pair_base = 10'h300;
        endcase
    endfunction

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
    import ioreg_pkg::*;
#(
    parameter int unsigned IO_AW = 10
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       loc,
    output reg_sel_e         sel
);
    logic [IO_AW-1:0] base;

    always_comb begin
        base = IO_AW'(pair_base(loc));
        if (io_addr == IO_AW'(ADR_LED))          sel = SEL_LED;
        else if (io_addr == IO_AW'(ADR_FLASH))   sel = SEL_FLASH;
        else if (io_addr == IO_AW'(ADR_LOC))     sel = SEL_LOC;
        else if (io_addr == base)                sel = SEL_STAT;
        else if (io_addr == base + IO_AW'(1))    sel = SEL_PAGE;
        else                                     sel = SEL_NONE;
    end
endmodule

// File: rtl/ioreg_bank.sv
module ioreg_bank
    import ioreg_pkg::*;
#(
    parameter int unsigned FPAGE_W = 4,
    parameter int unsigned SPAGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_sel_e           wr_sel,
    input  logic [7:0]         wr_data,
    input  reg_sel_e           rd_sel,
    input  logic               disk_en,
    input  logic               video_en,
    input  logic               cmos_ok,
    input  logic               batt_fail,
    input  logic [3:0]         panel_sel,
    output logic [7:0]         rd_data,
    output logic [1:0]         loc,
    output logic [FPAGE_W-1:0] flash_page,
    output logic [SPAGE_W-1:0] sram_page,
    output logic               flash_en
);
    logic rsv5;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc        <= 2'b00;
            flash_page <= '0;
            sram_page  <= '0;
            flash_en   <= 1'b0;
            rsv5       <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_LED:   flash_en   <= wr_data[5];
                SEL_FLASH: flash_page <= wr_data[FPAGE_W-1:0];
                SEL_LOC:   loc        <= wr_data[7:6];
                SEL_PAGE: begin
                    sram_page <= wr_data[SPAGE_W-1:0];
                    rsv5      <= wr_data[5];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = 8'h00;
        unique case (rd_sel)
            SEL_LED:   rd_data = {cmos_ok, video_en, flash_en, 3'b000, disk_en, 1'b0};
            SEL_FLASH: begin
                rd_data[7:4]         = panel_sel;
                rd_data[FPAGE_W-1:0] = flash_page;
            end
            SEL_LOC:   rd_data = {loc, 6'b000000};
            SEL_STAT:  rd_data = {7'b0000000, batt_fail};
            SEL_PAGE:  begin
                rd_data[5]           = rsv5;
                rd_data[SPAGE_W-1:0] = sram_page;
            end
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/mem_window.sv
module mem_window #(
    parameter int unsigned      AW     = 20,
    parameter int unsigned      WIN_AW = 14,
    parameter logic [AW-1:0]    BASE   = '0
) (
    input  logic [AW-1:0] addr,
    input  logic          strobe,
    input  logic          gate,
    output logic          cs_n
);
    localparam int unsigned TAG_W = AW - WIN_AW;
    localparam logic [TAG_W-1:0] TAG = BASE[AW-1:WIN_AW];

    assign cs_n = !(strobe && gate && (addr[AW-1:WIN_AW] == TAG));
endmodule

// File: rtl/ioreg_glue.sv
module ioreg_glue
    import ioreg_pkg::*;
#(
    parameter int unsigned   MEM_AW      = 20,
    parameter int unsigned   IO_AW       = 10,
    parameter int unsigned   FPAGE_W     = 4,
    parameter int unsigned   SPAGE_W     = 3,
    parameter int unsigned   FWIN_AW     = 15,
    parameter int unsigned   SWIN_AW     = 14,
    parameter int unsigned   LO_W        = 15,
    parameter logic [19:0]   FLASH_BASE  = 20'hD0000,
    parameter logic [19:0]   SRAM_BASE   = 20'hCC000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MEM_AW-1:0]  bus_addr,
    input  logic [7:0]         data_in,
    output logic [7:0]         data_out,
    output logic               data_oe,
    input  logic               ior_n,
    input  logic               iow_n,
    input  logic               memr_n,
    input  logic               memw_n,
    input  logic               disk_en,
    input  logic               video_en,
    input  logic               cmos_ok,
    input  logic               batt_fail,
    input  logic [3:0]         panel_sel,
    output logic [FPAGE_W-1:0] flash_page,
    output logic [SPAGE_W-1:0] sram_page,
    output logic [LO_W-1:0]    dev_addr,
    output logic               flash_cs_n,
    output logic               sram_cs_n
);
    localparam logic [MEM_AW-1:0] FBASE = MEM_AW'(FLASH_BASE);
    localparam logic [MEM_AW-1:0] SBASE = MEM_AW'(SRAM_BASE);

    bus_st_e    state_q, state_d;
    reg_sel_e   sel, wr_sel_q;
    logic [7:0] wr_data_q;
    logic [7:0] rd_data;
    logic [1:0] loc;
    logic       flash_en;
    logic       mem_strobe;

    ioreg_decode #(.IO_AW(IO_AW)) u_dec (
        .io_addr (bus_addr[IO_AW-1:0]),
        .loc     (loc),
        .sel     (sel)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wr_sel_q  <= SEL_NONE;
            wr_data_q <= 8'h00;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && !iow_n && sel != SEL_NONE) begin
                wr_sel_q  <= sel;
                wr_data_q <= data_in;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!iow_n && sel != SEL_NONE) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_WAIT;
            ST_WAIT:  if (iow_n) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    ioreg_bank #(.FPAGE_W(FPAGE_W), .SPAGE_W(SPAGE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (state_q == ST_WRITE),
        .wr_sel     (wr_sel_q),
        .wr_data    (wr_data_q),
        .rd_sel     (sel),
        .disk_en    (disk_en),
        .video_en   (video_en),
        .cmos_ok    (cmos_ok),
        .batt_fail  (batt_fail),
        .panel_sel  (panel_sel),
        .rd_data    (rd_data),
        .loc        (loc),
        .flash_page (flash_page),
        .sram_page  (sram_page),
        .flash_en   (flash_en)
    );

    // outputs
    always_comb begin
        data_oe  = !ior_n && (sel != SEL_NONE);
        data_out = data_oe ? rd_data : 8'h00;
    end

    assign mem_strobe = !memr_n || !memw_n;
    assign dev_addr   = bus_addr[LO_W-1:0];

    mem_window #(.AW(MEM_AW), .WIN_AW(FWIN_AW), .BASE(FBASE)) u_fwin (
        .addr   (bus_addr),
        .strobe (mem_strobe),
        .gate   (flash_en),
        .cs_n   (flash_cs_n)
    );

    mem_window #(.AW(MEM_AW), .WIN_AW(SWIN_AW), .BASE(SBASE)) u_swin (
        .addr   (bus_addr),
        .strobe (mem_strobe),
        .gate   (1'b1),
        .cs_n   (sram_cs_n)
    );
endmodule

// File: rtl/ioreg_glue_chk.sv
module ioreg_glue_chk
    import ioreg_pkg::*;
#(
    parameter int unsigned FPAGE_W = 4,
    parameter int unsigned SPAGE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ior_n,
    input logic               memr_n,
    input logic               memw_n,
    input logic               data_oe,
    input logic               flash_cs_n,
    input logic               sram_cs_n,
    input logic               flash_en,
    input logic [FPAGE_W-1:0] flash_page,
    input logic [SPAGE_W-1:0] sram_page,
    input bus_st_e            state_q
);
    assert_oe_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ior_n);

    assert_sram_cs_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs_n |-> (!memr_n || !memw_n));

    assert_flash_cs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> (flash_en && (!memr_n || !memw_n)));

    assert_write_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |=> (state_q == ST_WAIT));

    assert_fpage_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WRITE) |=> $stable(flash_page));

    assert_spage_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WRITE) |=> $stable(sram_page));
endmodule

bind ioreg_glue ioreg_glue_chk #(.FPAGE_W(FPAGE_W), .SPAGE_W(SPAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ior_n      (ior_n),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .data_oe    (data_oe),
    .flash_cs_n (flash_cs_n),
    .sram_cs_n  (sram_cs_n),
    .flash_en   (flash_en),
    .flash_page (flash_page),
    .sram_page  (sram_page),
    .state_q    (state_q)
);

// File: tb/sim_ioreg_glue.sv
`timescale 1ns/1ps
module sim_ioreg_glue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic        disk_en = 1'b1, video_en = 1'b0, cmos_ok = 1'b1, batt_fail = 1'b0;
    logic [3:0]  panel_sel = 4'hA;
    logic [3:0]  flash_page;
    logic [2:0]  sram_page;
    logic [14:0] dev_addr;
    logic        flash_cs_n, sram_cs_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] rd;

    always #10 clk = ~clk;

    ioreg_glue u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic io_wr(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; data_in = d; iow_n = 1'b0;
        repeat (3) @(negedge clk);
        iow_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic io_rd(input logic [19:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk); bus_addr = a; ior_n = 1'b0;
        #3; d = data_out; oe = data_oe;
        @(negedge clk); ior_n = 1'b1;
    endtask

    task automatic mem_probe(input logic [19:0] a, input logic wr,
                             output logic fcs, output logic scs);
        @(negedge clk); bus_addr = a;
        if (wr) memw_n = 1'b0; else memr_n = 1'b0;
        #3; fcs = flash_cs_n; scs = sram_cs_n;
        memr_n = 1'b1; memw_n = 1'b1;
    endtask

    task automatic t_reset;
        logic oe;
        chk("R1 flash_page", flash_page, 0);
        chk("R1 sram_page", sram_page, 0);
        io_rd(20'h234, rd, oe); chk("R1 loc", rd, 8'h00);
        io_rd(20'h181, rd, oe); chk("R1 page reg", rd, 8'h00);
        io_rd(20'h231, rd, oe); chk("R2 led reset", rd, 8'b1000_0010);
    endtask

    task automatic t_led;
        logic oe;
        io_wr(20'h231, 8'hFF);
        io_rd(20'h231, rd, oe); chk("R2 led bit5 set", rd, 8'b1010_0010);
        io_wr(20'h231, 8'h00);
        io_rd(20'h231, rd, oe); chk("R2 led bit5 clr", rd, 8'b1000_0010);
    endtask

    task automatic t_flash_reg;
        logic oe;
        io_wr(20'h233, 8'h5C);
        io_rd(20'h233, rd, oe); chk("R3 flash reg", rd, 8'hAC);
        chk("R3 flash_page", flash_page, 4'hC);
    endtask

    task automatic t_reloc;
        logic oe;
        logic [9:0] bases [4] = '{10'h180, 10'h2E0, 10'h3E0, 10'h300};
        for (int i = 0; i < 4; i++) begin
            io_wr(20'h234, {i[1:0], 6'h3F});
            io_rd(20'h234, rd, oe); chk("R4 loc read", rd, {i[1:0], 6'h00});
            io_wr({10'h0, bases[i] + 10'd1}, 8'h25 + 8'(i));
            io_rd({10'h0, bases[i] + 10'd1}, rd, oe);
            chk("R6 page reg", rd, (8'h25 + 8'(i)) & 8'h27);
            chk("R6 sram_page", sram_page, 3'((8'h25 + 8'(i)) & 8'h07));
            io_rd({10'h0, bases[i]}, rd, oe); chk("R5 batt good", rd, 8'h00);
            if (i > 0) begin
                io_rd({10'h0, bases[i-1]}, rd, oe); chk("R4 old base silent", oe, 0);
            end
        end
        batt_fail = 1'b1;
        io_rd(20'h300, rd, oe); chk("R5 batt failed", rd, 8'h01);
        io_wr(20'h300, 8'hFE);
        io_rd(20'h300, rd, oe); chk("R5 write ignored", rd, 8'h01);
        io_wr(20'h234, 8'h00);
        io_rd(20'h180, rd, oe); chk("R4 back to 180h", oe, 1);
    endtask

    task automatic t_tristate;
        logic oe;
        io_rd(20'h232, rd, oe); chk("R9 undecoded", oe, 0);
        io_rd(20'h631, rd, oe); chk("R10 alias oe", oe, 1);
        chk("R10 alias data", rd, 8'b1000_0010);
        @(negedge clk); bus_addr = 20'h231; #3; chk("R9 no strobe", data_oe, 0);
    endtask

    task automatic t_windows;
        logic f, s;
        mem_probe(20'hCBFFF, 0, f, s); chk("R7 below sram", s, 1);
        mem_probe(20'hCC000, 0, f, s); chk("R7 sram low", s, 0);
        mem_probe(20'hCFFFF, 1, f, s); chk("R7 sram high", s, 0);
        mem_probe(20'hD0000, 0, f, s); chk("R7 above sram", s, 1);
        chk("R8 flash closed", f, 1);
        @(negedge clk); bus_addr = 20'hCC010; #3; chk("R7 no strobe", sram_cs_n, 1);
        io_wr(20'h231, 8'h20);
        mem_probe(20'hD0000, 0, f, s); chk("R8 flash low", f, 0);
        mem_probe(20'hD7FFF, 1, f, s); chk("R8 flash high", f, 0);
        mem_probe(20'hD8000, 0, f, s); chk("R8 past flash", f, 1);
        mem_probe(20'hCFFFF, 0, f, s); chk("R8 below flash", f, 1);
        @(negedge clk); bus_addr = 20'hD5A5A; #3;
        chk("R10 dev_addr", dev_addr, 15'h5A5A);
    endtask

    task automatic t_single_commit;
        @(negedge clk); bus_addr = 20'h233; data_in = 8'h03; iow_n = 1'b0;
        repeat (2) @(negedge clk);
        data_in = 8'h09;
        repeat (4) @(negedge clk);
        iow_n = 1'b1;
        @(negedge clk);
        chk("R11 one commit", flash_page, 4'h3);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_led();
                t_flash_reg();
                t_reloc();
                t_tristate();
                t_windows();
                t_single_commit();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule